// File: doc/BRIEF.md
# Cascadable Serial-to-Parallel Shift Register with Storage Stage

The block converts a serial bit stream into a parallel word. Serial data enters a chain of shift stages on each rising edge of the shift clock. A separate storage clock copies the whole chain into a second bank of flip-flops in one step. The parallel outputs come from that second bank, so they stay steady while new data shifts in behind them.

Each register has its own asynchronous active-low clear. The last shift stage is also driven out as a serial cascade output. That output can feed the serial input of another copy of the block, which builds a longer chain. If one signal drives both clocks, the outputs always trail the shift chain by one edge. The word width is a parameter with a default of 8. Widths of 1 and up are accepted.

Top module: `cascade_shift_store`

## Requirements
- R1: On each rising edge of `sh_clk` while `sh_clr_n` is high, shift stage 0 takes `ser_in` and each stage i>0 takes the former value of stage i-1. Stage index equals bit position.
- R2: On each rising edge of `st_clk` while `st_clr_n` is high, all W shift stages are copied at once into the storage bank, and `par_out[i]` shows stage i.
- R3: While `sh_clr_n` is low, every shift stage reads zero regardless of `sh_clk`, and the storage bank keeps its value.
- R4: While `st_clr_n` is low, `par_out` reads zero regardless of `st_clk`, and the shift stages keep their value.
- R5: Changes on `ser_in` with no rising clock edge, and falling edges of either clock, leave both registers unchanged.
- R6: `casc_out` is shift stage W-1, not the storage bank. After shifts with no storage edge, it can differ from `par_out[W-1]`.
- R7: With `sh_clk` and `st_clk` driven by one signal, after each edge `par_out` equals the shift contents from before that edge.
- R8: A clock edge that arrives while that register's clear is still low has no effect. After the clear is released, the register stays zero until its next rising edge.
- R9: Two instances chained through `casc_out`, sharing clocks and clears, behave as one 2W-stage register. The first instance holds bits [W-1:0] and the second holds bits [2W-1:W].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ser_in | input | 1 | Serial data into shift stage 0 |
| sh_clk | input | 1 | Shift clock, rising edge active |
| sh_clr_n | input | 1 | Asynchronous active-low clear of the shift stages |
| st_clk | input | 1 | Storage clock, rising edge active |
| st_clr_n | input | 1 | Asynchronous active-low clear of the storage bank |
| par_out | output | W | Storage bank contents |
| casc_out | output | 1 | Last shift stage, for chaining |

## Verification
The bench builds two instances with the default W of 8. It chains them through the cascade output, so a 16-bit reference model covers both the stage-to-stage shift inside each instance and the hand-off across the instance boundary. W of 8 leaves the final stage of each instance observable on `casc_out` and on the top bit of `par_out`, so the check that the cascade output comes from the shift stages and not the storage bank can be made. Random mixes of shift, store, tied-clock, clear and idle steps are combined with directed cases: a clock edge while a clear is held low, a falling edge just after a clear is released, and a known 16-bit pattern shifted through the chain.

// File: rtl/css_pkg.sv
package css_pkg;
    // Default word width of one device in the chain.
    parameter int unsigned CSS_WIDTH = 8;
endpackage

// File: rtl/css_shift_path.sv
module css_shift_path #(
    parameter int unsigned W = css_pkg::CSS_WIDTH
) (
    input  logic         clk,
    input  logic         clr_n,
    input  logic         ser_in,
    output logic [W-1:0] stages
);
    typedef struct packed {
        logic [W-1:0] bits;
    } sh_state_t;

    sh_state_t st_d, st_q;

    generate
        if (W == 1) begin : g_single
            always_comb begin
                st_d      = st_q;
                st_d.bits = ser_in;
            end
        end else begin : g_multi
            always_comb begin
                st_d      = st_q;
                st_d.bits = {st_q.bits[W-2:0], ser_in};
            end
        end
    endgenerate

    // Clear is sampled inside the edge branch too, so a low clear at a clock edge wins.
    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign stages = st_q.bits;
endmodule

// File: rtl/css_hold_path.sv
module css_hold_path #(
    parameter int unsigned W = css_pkg::CSS_WIDTH
) (
    input  logic         clk,
    input  logic         clr_n,
    input  logic [W-1:0] par_in,
    output logic [W-1:0] par_out
);
    typedef struct packed {
        logic [W-1:0] word;
    } hold_state_t;

    hold_state_t hd_d, hd_q;

    always_comb begin
        hd_d      = hd_q;
        hd_d.word = par_in;
    end

    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) begin
            hd_q <= '0;
        end else begin
            hd_q <= hd_d;
        end
    end

    assign par_out = hd_q.word;
endmodule

// File: rtl/cascade_shift_store.sv
module cascade_shift_store #(
    parameter int unsigned W = css_pkg::CSS_WIDTH
) (
    input  logic         ser_in,
    input  logic         sh_clk,
    input  logic         sh_clr_n,
    input  logic         st_clk,
    input  logic         st_clr_n,
    output logic [W-1:0] par_out,
    output logic         casc_out
);
    logic [W-1:0] shift_bits;

    css_shift_path #(.W(W)) u_shift (
        .clk    (sh_clk),
        .clr_n  (sh_clr_n),
        .ser_in (ser_in),
        .stages (shift_bits)
    );

    css_hold_path #(.W(W)) u_hold (
        .clk     (st_clk),
        .clr_n   (st_clr_n),
        .par_in  (shift_bits),
        .par_out (par_out)
    );

    // Cascade taps the final shift stage (R6).
    assign casc_out = shift_bits[W-1];
endmodule

// File: rtl/css_checker.sv
module css_checker #(
    parameter int unsigned W = css_pkg::CSS_WIDTH
) (
    input logic         ser_in,
    input logic         sh_clk,
    input logic         sh_clr_n,
    input logic         st_clk,
    input logic         st_clr_n,
    input logic [W-1:0] shift_bits,
    input logic [W-1:0] par_out
);
    // Set by a clear, dropped by the next clean edge: marks edges whose previous sample is stale.
    logic sh_fresh, st_fresh;

    always_ff @(posedge sh_clk or negedge sh_clr_n) begin
        if (!sh_clr_n) sh_fresh <= 1'b1;
        else           sh_fresh <= 1'b0;
    end

    always_ff @(posedge st_clk or negedge st_clr_n) begin
        if (!st_clr_n) st_fresh <= 1'b1;
        else           st_fresh <= 1'b0;
    end

    generate
        if (W > 1) begin : g_shift_chk
            a_r1_shift_moves: assert property (@(posedge sh_clk) disable iff (!sh_clr_n)
                !sh_fresh |-> shift_bits == {$past(shift_bits[W-2:0]), $past(ser_in)});
        end else begin : g_shift_chk1
            a_r1_shift_moves: assert property (@(posedge sh_clk) disable iff (!sh_clr_n)
                !sh_fresh |-> shift_bits[0] == $past(ser_in));
        end
    endgenerate

    a_r2_store_copies: assert property (@(posedge st_clk) disable iff (!st_clr_n)
        !st_fresh |-> par_out == $past(shift_bits));

    // R8: first edge after a clear sees an all-zero register.
    a_r8_shift_zero_after_clear: assert property (@(posedge sh_clk) disable iff (!sh_clr_n)
        sh_fresh |-> shift_bits == '0);

    a_r8_store_zero_after_clear: assert property (@(posedge st_clk) disable iff (!st_clr_n)
        st_fresh |-> par_out == '0);

    always @(negedge sh_clk) begin
        if (!sh_clr_n) begin
            a_r3_shift_held_clear: assert (shift_bits == '0);
        end
    end

    always @(negedge st_clk) begin
        if (!st_clr_n) begin
            a_r4_store_held_clear: assert (par_out == '0);
        end
    end
endmodule

bind cascade_shift_store css_checker #(.W(W)) chk_i (
    .ser_in     (ser_in),
    .sh_clk     (sh_clk),
    .sh_clr_n   (sh_clr_n),
    .st_clk     (st_clk),
    .st_clr_n   (st_clr_n),
    .shift_bits (shift_bits),
    .par_out    (par_out)
);

// File: tb/cascade_shift_store_tb_top.sv
`timescale 1ns/1ps
module cascade_shift_store_tb_top;
    localparam int W  = 8;
    localparam int CW = 2 * W;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic sh_clk = 1'b0, st_clk = 1'b0;
    logic sh_clr_n = 1'b0, st_clr_n = 1'b0;
    logic ser_in = 1'b0;
    logic [W-1:0] par_a, par_b;
    logic casc_a, casc_b;

    cascade_shift_store #(.W(W)) dut_i (
        .ser_in(ser_in), .sh_clk(sh_clk), .sh_clr_n(sh_clr_n),
        .st_clk(st_clk), .st_clr_n(st_clr_n), .par_out(par_a), .casc_out(casc_a));

    cascade_shift_store #(.W(W)) tail_i (
        .ser_in(casc_a), .sh_clk(sh_clk), .sh_clr_n(sh_clr_n),
        .st_clk(st_clk), .st_clr_n(st_clr_n), .par_out(par_b), .casc_out(casc_b));

    logic [CW-1:0] m_sh = '0, m_st = '0;
    int checks = 0, errors = 0, cyc = 0;

    function automatic logic [CW-1:0] f_shift(logic [CW-1:0] s, logic b);
        return {s[CW-2:0], b};
    endfunction

    task automatic check(string req, string what, logic [CW-1:0] got, logic [CW-1:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s got %h expected %h", req, what, got, exp);
        end
    endtask

    task automatic check_all(string req);
        check(req, "par_out", {par_b, par_a}, m_st);
        check(req, "casc_out", {{(CW-2){1'b0}}, casc_b, casc_a},
              {{(CW-2){1'b0}}, m_sh[CW-1], m_sh[W-1]});
    endtask

    task automatic do_shift(logic b);
        ser_in = b; #2 sh_clk = 1'b1; #4 sh_clk = 1'b0; #2;
        m_sh = f_shift(m_sh, b);
    endtask

    task automatic do_store();
        #2 st_clk = 1'b1; #4 st_clk = 1'b0; #2;
        m_st = m_sh;
    endtask

    task automatic do_both(logic b);
        ser_in = b; #2 begin sh_clk = 1'b1; st_clk = 1'b1; end
        #4 begin sh_clk = 1'b0; st_clk = 1'b0; end #2;
        m_st = m_sh;
        m_sh = f_shift(m_sh, b);
    endtask

    task automatic clear_sh();
        #1 sh_clr_n = 1'b0; #2 sh_clr_n = 1'b1; #1;
        m_sh = '0;
    endtask

    task automatic clear_st();
        #1 st_clr_n = 1'b0; #2 st_clr_n = 1'b1; #1;
        m_st = '0;
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            errors++;
            $display("FAIL R9 watchdog got running expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20417));
        // Reset with both clocks pulsed while clears are low.
        #3 begin sh_clk = 1'b1; st_clk = 1'b1; ser_in = 1'b1; end
        #4 begin sh_clk = 1'b0; st_clk = 1'b0; end
        #2 begin sh_clr_n = 1'b1; st_clr_n = 1'b1; end
        #3;
        check_all("R3");

        // R1 / R9: known 16-bit pattern through the chain.
        for (int i = CW - 1; i >= 0; i--) begin
            logic [CW-1:0] pat = 16'hA5C3;
            do_shift(pat[i]);
        end
        check_all("R1");
        do_store();
        check_all("R9");
        check("R2", "par_out pattern", {par_b, par_a}, 16'hA5C3);

        // R6: shifts with no store, cascade follows shift stages.
        do_shift(1'b0); do_shift(1'b1);
        check_all("R6");

        // R5: data toggles without an edge change nothing.
        for (int i = 0; i < 5; i++) begin ser_in = ~ser_in; #3; end
        check_all("R5");
        do_store();
        check_all("R5");

        // R4: storage clear leaves shift stages alone.
        clear_st();
        check_all("R4");
        do_store();
        check_all("R4");

        // R3: shift clear leaves storage alone.
        do_shift(1'b1);
        clear_sh();
        check_all("R3");
        do_store();
        check_all("R3");

        // R8 and R5: edge while clear low, release while clock high, then falling edge.
        for (int i = 0; i < 6; i++) do_shift(1'b1);
        do_store();
        #1 sh_clr_n = 1'b0; m_sh = '0;
        ser_in = 1'b1; #2 sh_clk = 1'b1; #2 sh_clr_n = 1'b1; #2 sh_clk = 1'b0; #2;
        check_all("R8");
        #1 st_clr_n = 1'b0; m_st = '0;
        #2 st_clk = 1'b1; #2 st_clr_n = 1'b1; #2 st_clk = 1'b0; #2;
        check_all("R8");
        do_store();
        check_all("R8");

        // R7: tied clocks, outputs trail by one edge.
        for (int i = 0; i < 20; i++) begin
            do_both(1'($urandom_range(0, 1)));
            check_all("R7");
        end

        // Random mix.
        for (int i = 0; i < 600; i++) begin
            case ($urandom_range(0, 6))
                0, 1: begin do_shift(1'($urandom_range(0, 1))); check_all("R1"); end
                2:    begin do_store(); check_all("R2"); end
                3:    begin do_both(1'($urandom_range(0, 1))); check_all("R7"); end
                4:    begin clear_sh(); check_all("R3"); end
                5:    begin clear_st(); check_all("R4"); end
                default: begin ser_in = ~ser_in; #4; check_all("R5"); end
            endcase
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule